// File: doc/BRIEF.md
# Configurable CFAR Threshold Detector

This block makes a streaming target/no-target decision with a constant false alarm rate. One sample arrives per accepted clock. The samples move through a single delay line. The newest part of the line is the lagging reference window. Next come a guard band, the cell under test and a second guard band. The oldest part of the line is the leading reference window. From the two reference windows the block estimates the local noise level Z and multiplies it by a programmable fixed-point factor. The block raises its flag when the cell under test is strictly above that threshold.

Each window can supply two kinds of value, and both are always available. The first is its running mean. The second is a value picked by rank from that window's contents. A one-bit operation select chooses which kind feeds the statistic. A two-bit statistic select then takes the mean, the larger or the smaller of the two side values. Together these two selects give six detectors: cell-averaging, greatest-of and smallest-of, each in a linear form and a rank-order form. All of them are evaluated from the same window contents, so the detector can be switched on any cycle. Setting both rank indices equal gives the classic order-statistic forms.

Top module: `cfar_detector`

## Requirements
- R1: While `rst_n` is low, `det_valid` and `det_flag` read 0. After reset, the delay line and both running sums start from zero, and the fill count starts again.
- R2: `det_valid` stays 0 until 2·NREF+2·NGUARD+1 samples have been accepted. From the cycle after the clock edge that accepts the last of those samples, it reads 1 on every cycle, and `det_flag` is a fresh decision on every cycle. `det_flag` is 0 whenever `det_valid` is 0.
- R3: A sample is accepted only on a clock edge with `smp_valid` high; otherwise the delay line and the sums hold. The lagging window is the NREF most recent samples. The cell under test is the sample accepted NREF+NGUARD samples before the newest one. The leading window is the NREF oldest samples in the line. The guard samples have no effect on the decision.
- R4: With `op_rank` = 0, the two side values are each window's mean, truncated to an integer: the running sum shifted right by log2(NREF).
- R5: With `op_rank` = 1, the lagging value is the `rank_lag`-th largest sample of the lagging window and the leading value is the `rank_lead`-th largest sample of the leading window. Ranks are 1-based, rank 1 is the largest, and equal samples each take their own rank.
- R6: A rank index of 0 acts as 1, and a rank index above NREF acts as NREF.
- R7: `stat_sel` code 0 or 3 gives Z as half the sum of the two side values, with the half kept exactly. Code 1 gives the larger of the two and code 2 the smaller.
- R8: `scale` is unsigned with FRAC fractional bits (with FRAC = 10, 1024 means 1.0 and 973 means 0.9501953125). The flag is 1 exactly when CUT > scale·Z in full precision; equality gives 0.
- R9: A change of `op_rank`, `stat_sel`, `rank_lag`, `rank_lead` or `scale` shows in the output register at the next clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; the line shifts when high |
| smp_data | input | DW | Unsigned sample amplitude |
| op_rank | input | 1 | 0: window means, 1: rank-picked values |
| stat_sel | input | 2 | 0/3 half-sum, 1 maximum, 2 minimum |
| rank_lag | input | RW | 1-based rank picked from the lagging window |
| rank_lead | input | RW | 1-based rank picked from the leading window |
| scale | input | SCW | Unsigned threshold factor, FRAC fractional bits |
| det_valid | output | 1 | Window full; decision is meaningful |
| det_flag | output | 1 | Target declared for the current cell under test |

## Verification
The bench builds the block with NREF = 4 and NGUARD = 1, so the whole line is 11 samples. Every rank position of a window and every clamp case can be reached with a short push. The 3-bit rank index at that size reaches 7, which is above the window, as well as 0, so both clamp directions can be driven. DW = 12, SCW = 16 and FRAC = 10 leave room for threshold factors above 1.0. They also let an exact half-sum and an exact tie between CUT and threshold be set up with small integers.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

    typedef enum logic {
        OP_LINEAR = 1'b0,
        OP_RANK   = 1'b1
    } op_mode_t;

    typedef enum logic [1:0] {
        STAT_MEAN     = 2'd0,
        STAT_MAX      = 2'd1,
        STAT_MIN      = 2'd2,
        STAT_MEAN_ALT = 2'd3
    } stat_mode_t;

endpackage

// File: rtl/cfar_running_sum.sv
module cfar_running_sum #(
    parameter int DW = 12,
    parameter int N  = 16,
    localparam int SW = DW + $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] enter,
    input  logic [DW-1:0] leave,
    output logic [SW-1:0] sum
);

    localparam logic [SW-1:0] SUM_MAX = SW'(N) * SW'((2 ** DW) - 1);

    logic [SW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (en) begin
            sum_d = sum_q + SW'(enter) - SW'(leave);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= SUM_MAX); // R4

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sum_q)); // R3

endmodule

// File: rtl/cfar_rank_pick.sv
module cfar_rank_pick #(
    parameter int DW = 12,
    parameter int N  = 16,
    parameter int RW = $clog2(N) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0][DW-1:0] cells,
    input  logic [RW-1:0]        rank_raw,
    output logic [DW-1:0]        picked
);

    logic [RW-1:0] rank_c;
    logic [N-1:0]  hit_vec;

    // Clamp the requested rank into 1..N
    always_comb begin
        if (rank_raw == '0) begin
            rank_c = RW'(1);
        end else if (rank_raw > RW'(N)) begin
            rank_c = RW'(N);
        end else begin
            rank_c = rank_raw;
        end
    end

    // Each cell's place = cells strictly larger + equal cells at lower index
    for (genvar j = 0; j < N; j++) begin : g_place
        logic [RW-1:0] place;
        always_comb begin
            place = '0;
            for (int p = 0; p < N; p++) begin
                if ((cells[p] > cells[j]) || ((p < j) && (cells[p] == cells[j]))) begin
                    place = place + RW'(1);
                end
            end
        end
        assign hit_vec[j] = ((place + RW'(1)) == rank_c);
    end

    always_comb begin
        picked = '0;
        for (int j = 0; j < N; j++) begin
            picked = picked | ({DW{hit_vec[j]}} & cells[j]);
        end
    end

    // Support logic for the ordering check
    logic [RW-1:0] n_above, n_at_or_above;
    always_comb begin
        n_above       = '0;
        n_at_or_above = '0;
        for (int p = 0; p < N; p++) begin
            if (cells[p] > picked)  n_above       = n_above + RW'(1);
            if (cells[p] >= picked) n_at_or_above = n_at_or_above + RW'(1);
        end
    end

    AST_RANK_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_c != '0) && (rank_c <= RW'(N))); // R6

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) == 1); // R5

    AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (n_above < rank_c) && (n_at_or_above >= rank_c)); // R5

endmodule

// File: rtl/cfar_detector.sv
module cfar_detector
    import cfar_pkg::*;
#(
    parameter int DW     = 12,
    parameter int NREF   = 16,
    parameter int NGUARD = 4,
    parameter int SCW    = 16,
    parameter int FRAC   = 10,
    localparam int RW    = $clog2(NREF) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic           op_rank,
    input  logic [1:0]     stat_sel,
    input  logic [RW-1:0]  rank_lag,
    input  logic [RW-1:0]  rank_lead,
    input  logic [SCW-1:0] scale,
    output logic           det_valid,
    output logic           det_flag
);

    localparam int LOG2N   = $clog2(NREF);
    localparam int LINE    = 2 * NREF + 2 * NGUARD + 1;
    localparam int CUT_IDX = NREF + NGUARD;
    localparam int LEAD_LO = NREF + 2 * NGUARD + 1;
    localparam int FW      = $clog2(LINE + 1);
    localparam int SUMW    = DW + LOG2N;
    localparam int PW      = SCW + DW + 2;

    typedef struct packed {
        logic [LINE-1:0][DW-1:0] win;
        logic [FW-1:0]           fill;
        logic                    vld;
        logic                    flag;
    } state_t;

    state_t st_d, st_q;

    logic [NREF-1:0][DW-1:0] lag_cells, lead_cells;
    logic [SUMW-1:0]         lag_sum, lead_sum;
    logic [DW-1:0]           lag_pick, lead_pick;
    logic [DW-1:0]           side_a, side_b, hi, lo;
    logic [DW:0]             z_twice;
    logic [PW-1:0]           cut_scaled, thr_scaled;
    logic                    above;

    always_comb begin
        for (int p = 0; p < NREF; p++) begin
            lag_cells[p]  = st_q.win[p];
            lead_cells[p] = st_q.win[LEAD_LO + p];
        end
    end

    cfar_running_sum #(.DW(DW), .N(NREF)) i_lag_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (smp_valid),
        .enter (smp_data),
        .leave (st_q.win[NREF-1]),
        .sum   (lag_sum)
    );

    cfar_running_sum #(.DW(DW), .N(NREF)) i_lead_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (smp_valid),
        .enter (st_q.win[LEAD_LO-1]),
        .leave (st_q.win[LINE-1]),
        .sum   (lead_sum)
    );

    cfar_rank_pick #(.DW(DW), .N(NREF), .RW(RW)) i_lag_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cells    (lag_cells),
        .rank_raw (rank_lag),
        .picked   (lag_pick)
    );

    cfar_rank_pick #(.DW(DW), .N(NREF), .RW(RW)) i_lead_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cells    (lead_cells),
        .rank_raw (rank_lead),
        .picked   (lead_pick)
    );

    // Statistic and threshold comparison; Z is carried as 2*Z to keep the half exact
    always_comb begin
        if (op_mode_t'(op_rank) == OP_RANK) begin
            side_a = lag_pick;
            side_b = lead_pick;
        end else begin
            side_a = DW'(lag_sum >> LOG2N);
            side_b = DW'(lead_sum >> LOG2N);
        end
        hi = (side_a > side_b) ? side_a : side_b;
        lo = (side_a > side_b) ? side_b : side_a;
        case (stat_mode_t'(stat_sel))
            STAT_MAX: z_twice = {hi, 1'b0};
            STAT_MIN: z_twice = {lo, 1'b0};
            default:  z_twice = {1'b0, side_a} + {1'b0, side_b};
        endcase
        thr_scaled = PW'(scale) * PW'(z_twice);
        cut_scaled = PW'(st_q.win[CUT_IDX]) << (FRAC + 1);
        above      = cut_scaled > thr_scaled;
    end

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.win = {st_q.win[LINE-2:0], smp_data};
            if (st_q.fill < FW'(LINE)) begin
                st_d.fill = st_q.fill + FW'(1);
            end
        end
        st_d.vld  = (st_q.fill == FW'(LINE));
        st_d.flag = st_d.vld && above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_valid = st_q.vld;
    assign det_flag  = st_q.flag;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !det_valid && !det_flag); // R1

    AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> (st_q.fill == FW'(LINE))); // R2

    AST_NO_FLAG_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !det_valid |-> !det_flag); // R2

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(st_q.win)); // R3

endmodule

// File: tb/test_cfar_detector.sv
`timescale 1ns/1ps
module test_cfar_detector;

    localparam int DW = 12, NREF = 4, NGUARD = 1, SCW = 16, FRAC = 10;
    localparam int RW = $clog2(NREF) + 1;
    localparam int NV = 16;

    typedef struct packed {
        logic        op;
        logic [1:0]  st;
        logic [2:0]  kl;
        logic [2:0]  kd;
        logic [15:0] sc;
        logic [11:0] cut;
        logic        ex;
        logic [3:0]  req;
    } vec_t;

    // Window: leading 40,10,30,20 (mean 25); lagging 8,16,4,12 (mean 10); guards 1000
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 3'd1, 3'd1, 16'd1024, 12'd18, 1'b1, 4'd7}, // R7 half-sum 17.5
        '{1'b0, 2'd0, 3'd1, 3'd1, 16'd1024, 12'd17, 1'b0, 4'd7}, // R7
        '{1'b0, 2'd1, 3'd1, 3'd1, 16'd1024, 12'd25, 1'b0, 4'd8}, // R8 equality
        '{1'b0, 2'd1, 3'd1, 3'd1, 16'd1024, 12'd26, 1'b1, 4'd4}, // R4 max of means
        '{1'b0, 2'd2, 3'd1, 3'd1, 16'd1024, 12'd11, 1'b1, 4'd4}, // R4 min of means
        '{1'b0, 2'd2, 3'd1, 3'd1, 16'd1024, 12'd10, 1'b0, 4'd8}, // R8
        '{1'b1, 2'd0, 3'd2, 3'd3, 16'd1024, 12'd17, 1'b1, 4'd5}, // R5 (12+20)/2
        '{1'b1, 2'd1, 3'd2, 3'd3, 16'd1024, 12'd20, 1'b0, 4'd5}, // R5 max 20
        '{1'b1, 2'd2, 3'd2, 3'd3, 16'd1024, 12'd13, 1'b1, 4'd5}, // R5 min 12
        '{1'b1, 2'd1, 3'd4, 3'd4, 16'd1024, 12'd11, 1'b1, 4'd5}, // R5 equal ranks
        '{1'b1, 2'd3, 3'd1, 3'd1, 16'd1024, 12'd28, 1'b0, 4'd7}, // R7 code 3
        '{1'b1, 2'd2, 3'd7, 3'd0, 16'd1024, 12'd5,  1'b1, 4'd6}, // R6 clamps, min 4
        '{1'b1, 2'd1, 3'd7, 3'd0, 16'd1024, 12'd40, 1'b0, 4'd6}, // R6 clamps, max 40
        '{1'b0, 2'd1, 3'd1, 3'd1, 16'd973,  12'd24, 1'b1, 4'd8}, // R8 thr 23.75
        '{1'b0, 2'd1, 3'd1, 3'd1, 16'd973,  12'd23, 1'b0, 4'd8}, // R8
        '{1'b0, 2'd2, 3'd1, 3'd1, 16'd2048, 12'd20, 1'b0, 4'd8}  // R8 thr 20
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           smp_valid;
    logic [DW-1:0]  smp_data;
    logic           op_rank;
    logic [1:0]     stat_sel;
    logic [RW-1:0]  rank_lag, rank_lead;
    logic [SCW-1:0] scale;
    logic           det_valid, det_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    cfar_detector #(.DW(DW), .NREF(NREF), .NGUARD(NGUARD), .SCW(SCW), .FRAC(FRAC)) i_cfar_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .op_rank   (op_rank),
        .stat_sel  (stat_sel),
        .rank_lag  (rank_lag),
        .rank_lead (rank_lead),
        .scale     (scale),
        .det_valid (det_valid),
        .det_flag  (det_flag)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v;
    endtask

    // Idle one edge (last push lands), then one more (output registers); ends at check point
    task automatic settle();
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_window(input logic [3:0][DW-1:0] lead, input logic [DW-1:0] cut,
                              input logic [3:0][DW-1:0] lag);
        for (int p = 0; p < 4; p++) push(lead[p]);
        push(12'd1000);
        push(cut);
        push(12'd1000);
        for (int p = 0; p < 4; p++) push(lag[p]);
        settle();
    endtask

    localparam logic [3:0][DW-1:0] LEAD_W = {12'd20, 12'd30, 12'd10, 12'd40};
    localparam logic [3:0][DW-1:0] LAG_W  = {12'd12, 12'd4, 12'd16, 12'd8};
    localparam logic [3:0][DW-1:0] FLAT_W = {12'd7, 12'd7, 12'd7, 12'd7};

    initial begin
        #800000;
        n_fails++;
        $display("FAIL all requirements: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        op_rank = 1'b0; stat_sel = 2'd0; rank_lag = 3'd1; rank_lead = 3'd1; scale = 16'd1024;
        repeat (3) @(negedge clk);
        check(det_valid, 1'b0, "R1 valid in reset");
        check(det_flag,  1'b0, "R1 flag in reset");
        rst_n = 1'b1;

        // R2: fill latency of 11 samples
        for (int p = 0; p < 10; p++) push(12'd0);
        settle();
        check(det_valid, 1'b0, "R2 after 10 samples");
        push(12'd0);
        settle();
        check(det_valid, 1'b1, "R2 after 11 samples");

        // Table of modes against one window
        for (int v = 0; v < NV; v++) begin
            op_rank   = TBL[v].op;
            stat_sel  = TBL[v].st;
            rank_lag  = TBL[v].kl;
            rank_lead = TBL[v].kd;
            scale     = TBL[v].sc;
            run_window(LEAD_W, TBL[v].cut, LAG_W);
            check(det_flag, TBL[v].ex, $sformatf("R%0d vector %0d", TBL[v].req, v));
        end

        // R9: scale change shows at the next edge only (threshold 20 -> 10, CUT 20)
        @(negedge clk);
        scale = 16'd1024;
        #1;
        check(det_flag, 1'b0, "R9 before edge");
        @(negedge clk);
        check(det_flag, 1'b1, "R9 after edge");

        // R3: samples without strobe are not accepted
        smp_data = 12'd4095;
        repeat (3) @(negedge clk);
        check(det_flag,  1'b1, "R3 flag held without strobe");
        check(det_valid, 1'b1, "R3 valid held");

        // R5: ties in both windows, greatest-of on rank 2 / rank 3 gives 7
        op_rank = 1'b1; stat_sel = 2'd1; rank_lag = 3'd2; rank_lead = 3'd3; scale = 16'd1024;
        run_window(FLAT_W, 12'd8, FLAT_W);
        check(det_flag, 1'b1, "R5 ties cut 8");
        run_window(FLAT_W, 12'd7, FLAT_W);
        check(det_flag, 1'b0, "R5 ties cut 7");

        // R1: reset mid-stream, then sums restart cleanly
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(det_valid, 1'b0, "R1 valid after mid reset");
        check(det_flag,  1'b0, "R1 flag after mid reset");
        rst_n = 1'b1;
        op_rank = 1'b0; stat_sel = 2'd0; rank_lag = 3'd1; rank_lead = 3'd1;
        run_window(LEAD_W, 12'd18, LAG_W);
        check(det_flag, 1'b1, "R1 sums restart, R4 mean");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule